// File: doc/BRIEF.md
# Video Memory Write Queue

This block holds host data writes that are bound for three video memories: a byte-wide pattern RAM, a 64-word colour RAM and a small vertical-scroll RAM. A host first loads a target register, which holds a 16-bit address and a 4-bit command code. It then issues data words through a ready/valid port. Each accepted word is stored in a four-entry circular queue together with the current address and the decoded target. The address register then steps forward by a programmable auto-increment.

The memory side works in access slots. An internal slot timer produces one slot pulse every 16 clocks in wide mode and every 20 clocks in narrow mode. On a slot pulse the oldest entry may drain, but only once three slots have passed since it was accepted. A pattern RAM write needs two slots, one byte in each. Colour and scroll writes need one slot. A slot with nothing ready to drain is flagged as unused. A status word reports whether the queue is empty or full.

Top module: `vram_wr_queue`

## Requirements
- R1: After reset the queue is empty: `stat_word` is 16'h0200, `host_ready` is high, and no memory write enable is asserted.
- R2: The queue holds 4 entries. While 4 entries are held, `host_ready` is low, and a pending write waits until an entry retires.
- R3: An entry drains no earlier than the 3rd slot pulse after the clock edge that accepted it. A slot pulse in the accepting cycle does not count.
- R4: `slot_pulse` repeats every 16 clocks while `wide_mode` is 1 and every 20 clocks while it is 0.
- R5: A pattern write (command low nibble 1) uses two slots. The first drives the high data byte to the entry address. The second drives the low byte to the address with bit 0 inverted, and then the entry retires.
- R6: A colour write (command 3) uses one slot and writes the whole 16-bit word at index address[6:1].
- R7: A scroll write (command 5) uses one slot at index address[6:1]. The write is suppressed when that index is 40 or more, but the slot is still consumed.
- R8: Any other command code consumes one slot and writes no memory.
- R9: `slot_idle` is high in a slot pulse cycle exactly when no entry is eligible to drain.
- R10: Entries drain in acceptance order, with at most one memory write enable per cycle, and only in a slot pulse cycle.
- R11: `tgt_load` sets the address and command. Each accepted write uses the current address, and the address then advances by `autoinc` modulo 2^16. A load in the same cycle as an accepted write takes priority over the advance.
- R12: `stat_word` bit 9 is set when the queue is empty and bit 8 when it is full. All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode | input | 1 | 1: 16-clock slots, 0: 20-clock slots |
| autoinc | input | 8 | Address step after each accepted write |
| tgt_load | input | 1 | Load the address and command registers |
| tgt_addr | input | 16 | Address to load |
| tgt_cmd | input | 4 | Command code to load |
| host_valid | input | 1 | Host data word offered |
| host_data | input | 16 | Host data word |
| host_ready | output | 1 | Queue can accept a word |
| slot_pulse | output | 1 | Access slot in this cycle |
| slot_idle | output | 1 | Slot found nothing to drain |
| pat_we | output | 1 | Pattern RAM byte write |
| pat_addr | output | 16 | Pattern RAM byte address |
| pat_byte | output | 8 | Pattern RAM byte |
| cram_we | output | 1 | Colour RAM write |
| cram_addr | output | 6 | Colour RAM index |
| cram_data | output | 16 | Colour RAM word |
| vs_we | output | 1 | Scroll RAM write |
| vs_addr | output | 6 | Scroll RAM index |
| vs_data | output | 16 | Scroll RAM word |
| stat_word | output | 16 | Status: bit 9 empty, bit 8 full |

## Verification
The bench builds the block with its defaults: 4 entries, 3-slot latency, 16/20-clock slots and a 40-word scroll RAM. With only four entries and a short slot, a burst of back-to-back pattern writes fills the queue within a few slots. This shows the stall and its release on retire. The 40-word scroll size leaves indices 40 to 63 reachable, so the suppressed-write path and the mod-64 index wrap can both be reached from ordinary addresses. An 8-bit step lets the address wrap past 16'hFFFF in two writes.

// File: rtl/vwq_pkg.sv
`timescale 1ns/1ps
package vwq_pkg;
  typedef logic [15:0] vaddr_t;
  typedef logic [15:0] vword_t;
  typedef logic [5:0]  widx_t;

  typedef enum logic [1:0] {TGT_NONE, TGT_PAT, TGT_CRAM, TGT_VS} tgt_e;

  typedef struct packed {
    vaddr_t addr;
    vword_t data;
    tgt_e   tgt;
  } qent_t;

  // Command low nibble selects the memory.
  function automatic tgt_e decode_cmd(input logic [3:0] nib);
    case (nib)
      4'h1:    return TGT_PAT;
      4'h3:    return TGT_CRAM;
      4'h5:    return TGT_VS;
      default: return TGT_NONE;
    endcase
  endfunction

  // Word index used by colour and scroll RAMs: (address/2) mod 64.
  function automatic widx_t word_index(input vaddr_t a);
    return a[6:1];
  endfunction

  function automatic vaddr_t step_addr(input vaddr_t a, input vaddr_t inc);
    return a + inc;
  endfunction
endpackage

// File: rtl/vwq_slot_timer.sv
`timescale 1ns/1ps
module vwq_slot_timer #(
  parameter int WIDE_CLKS   = 16,
  parameter int NARROW_CLKS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wide_mode,
  output logic strobe
);
  localparam int MAXC = (WIDE_CLKS > NARROW_CLKS) ? WIDE_CLKS : NARROW_CLKS;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_cnt;

  assign last_cnt = wide_mode ? CW'(WIDE_CLKS - 1) : CW'(NARROW_CLKS - 1);
  assign strobe   = (cnt_q >= last_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (strobe) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/vwq_store.sv
`timescale 1ns/1ps
module vwq_store
  import vwq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int LAT   = 3,
  parameter int AGW   = $clog2(LAT + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push,
  input  qent_t          push_ent,
  input  logic           pop,
  input  logic           mark_part,
  input  logic           strobe,
  output qent_t          head_ent,
  output logic [AGW-1:0] head_age,
  output logic           head_part,
  output logic           q_empty,
  output logic           q_full
);
  localparam int IW = $clog2(DEPTH);

  qent_t          slot_ent [DEPTH];
  logic [AGW-1:0] slot_age [DEPTH];
  logic [IW-1:0]  wr_q, rd_q, rd_next;
  logic           rd_valid_q, part_q;

  // Per-entry storage and slot-age counters.
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          slot_ent[i] <= '0;
      else if (push && wr_q == IW'(i))     slot_ent[i] <= push_ent;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                slot_age[i] <= '0;
      else if (push && wr_q == IW'(i))           slot_age[i] <= '0;
      else if (strobe && slot_age[i] < AGW'(LAT)) slot_age[i] <= slot_age[i] + 1'b1;
    end
  end

  assign rd_next = IW'(rd_q + 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q       <= '0;
      rd_q       <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      if (push) wr_q <= IW'(wr_q + 1'b1);
      if (pop)  rd_q <= rd_next;
      if (!rd_valid_q)                               rd_valid_q <= push;
      else if (pop && !push && rd_next == wr_q)      rd_valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         part_q <= 1'b0;
    else if (pop)       part_q <= 1'b0;
    else if (mark_part) part_q <= 1'b1;
  end

  assign head_ent  = slot_ent[rd_q];
  assign head_age  = slot_age[rd_q];
  assign head_part = part_q;
  assign q_empty   = !rd_valid_q;
  assign q_full    = rd_valid_q && (wr_q == rd_q);
endmodule

// File: rtl/vwq_drain.sv
`timescale 1ns/1ps
module vwq_drain
  import vwq_pkg::*;
#(
  parameter int LAT      = 3,
  parameter int VS_DEPTH = 40,
  parameter int AGW      = $clog2(LAT + 1)
) (
  input  logic           strobe,
  input  logic           has_head,
  input  qent_t          head_ent,
  input  logic [AGW-1:0] head_age,
  input  logic           head_part,
  output logic           pop,
  output logic           mark_part,
  output logic           idle,
  output logic           pat_we,
  output vaddr_t         pat_addr,
  output logic [7:0]     pat_byte,
  output logic           cram_we,
  output widx_t          cram_addr,
  output vword_t         cram_data,
  output logic           vs_we,
  output widx_t          vs_addr,
  output vword_t         vs_data
);
  logic  aged, go;
  widx_t idx;

  assign aged = (int'(head_age) >= LAT - 1);
  assign go   = strobe && has_head && (head_part || aged);
  assign idle = strobe && !go;
  assign idx  = word_index(head_ent.addr);

  assign pat_we   = go && head_ent.tgt == TGT_PAT;
  assign pat_addr = head_part ? (head_ent.addr ^ 16'h0001) : head_ent.addr;
  assign pat_byte = head_part ? head_ent.data[7:0] : head_ent.data[15:8];

  assign cram_we   = go && head_ent.tgt == TGT_CRAM;
  assign cram_addr = idx;
  assign cram_data = head_ent.data;

  assign vs_we   = go && head_ent.tgt == TGT_VS && (int'(idx) < VS_DEPTH);
  assign vs_addr = idx;
  assign vs_data = head_ent.data;

  assign mark_part = pat_we && !head_part;
  assign pop       = go && !mark_part;
endmodule

// File: rtl/vram_wr_queue.sv
`timescale 1ns/1ps
module vram_wr_queue
  import vwq_pkg::*;
#(
  parameter int DEPTH       = 4,
  parameter int LAT         = 3,
  parameter int WIDE_CLKS   = 16,
  parameter int NARROW_CLKS = 20,
  parameter int VS_DEPTH    = 40,
  parameter int INC_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wide_mode,
  input  logic [INC_W-1:0] autoinc,
  input  logic             tgt_load,
  input  logic [15:0]      tgt_addr,
  input  logic [3:0]       tgt_cmd,
  input  logic             host_valid,
  input  logic [15:0]      host_data,
  output logic             host_ready,
  output logic             slot_pulse,
  output logic             slot_idle,
  output logic             pat_we,
  output logic [15:0]      pat_addr,
  output logic [7:0]       pat_byte,
  output logic             cram_we,
  output logic [5:0]       cram_addr,
  output logic [15:0]      cram_data,
  output logic             vs_we,
  output logic [5:0]       vs_addr,
  output logic [15:0]      vs_data,
  output logic [15:0]      stat_word
);
  localparam int AGW = $clog2(LAT + 1);

  vaddr_t         addr_q;
  logic [3:0]     cmd_q;
  logic           push, pop, mark_part;
  logic           q_empty, q_full, head_part;
  qent_t          head_ent, push_ent;
  logic [AGW-1:0] head_age;

  assign host_ready = !q_full;
  assign push       = host_valid && host_ready;
  assign push_ent   = '{addr: addr_q, data: host_data, tgt: decode_cmd(cmd_q)};
  assign stat_word  = {6'b0, q_empty, q_full, 8'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cmd_q  <= '0;
    end else if (tgt_load) begin
      addr_q <= tgt_addr;
      cmd_q  <= tgt_cmd;
    end else if (push) begin
      addr_q <= step_addr(addr_q, vaddr_t'(autoinc));
    end
  end

  vwq_slot_timer #(.WIDE_CLKS(WIDE_CLKS), .NARROW_CLKS(NARROW_CLKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .strobe(slot_pulse)
  );

  vwq_store #(.DEPTH(DEPTH), .LAT(LAT), .AGW(AGW)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .push_ent(push_ent), .pop(pop),
    .mark_part(mark_part), .strobe(slot_pulse), .head_ent(head_ent),
    .head_age(head_age), .head_part(head_part), .q_empty(q_empty), .q_full(q_full)
  );

  vwq_drain #(.LAT(LAT), .VS_DEPTH(VS_DEPTH), .AGW(AGW)) u_drain (
    .strobe(slot_pulse), .has_head(!q_empty), .head_ent(head_ent),
    .head_age(head_age), .head_part(head_part), .pop(pop), .mark_part(mark_part),
    .idle(slot_idle), .pat_we(pat_we), .pat_addr(pat_addr), .pat_byte(pat_byte),
    .cram_we(cram_we), .cram_addr(cram_addr), .cram_data(cram_data),
    .vs_we(vs_we), .vs_addr(vs_addr), .vs_data(vs_data)
  );
endmodule

// File: rtl/vwq_chk.sv
`timescale 1ns/1ps
module vwq_chk #(
  parameter int WIDE_CLKS   = 16,
  parameter int NARROW_CLKS = 20,
  parameter int VS_DEPTH    = 40
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wide_mode,
  input logic        host_valid,
  input logic        host_ready,
  input logic        slot_pulse,
  input logic        slot_idle,
  input logic        pat_we,
  input logic [15:0] pat_addr,
  input logic        cram_we,
  input logic        vs_we,
  input logic [5:0]  vs_addr,
  input logic        q_empty,
  input logic        q_full
);
  logic        hi_seen;
  logic [15:0] lo_addr;
  logic [15:0] gap_q;
  logic        prev_wide, chg_q, gap_window;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_seen <= 1'b0;
      lo_addr <= '0;
    end else if (pat_we) begin
      hi_seen <= !hi_seen;
      lo_addr <= pat_addr ^ 16'h0001;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q     <= '0;
      prev_wide <= 1'b1;
      chg_q     <= 1'b0;
    end else begin
      prev_wide <= wide_mode;
      gap_q     <= slot_pulse ? '0 : gap_q + 1'b1;
      if (slot_pulse)                  chg_q <= 1'b0;
      else if (wide_mode != prev_wide) chg_q <= 1'b1;
    end
  end

  assign gap_window = !chg_q && (wide_mode == prev_wide);

  // R10
  one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pat_we, cram_we, vs_we}));

  // R10
  write_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_we || cram_we || vs_we) |-> slot_pulse);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_idle |-> (slot_pulse && !pat_we && !cram_we && !vs_we));

  // R2
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> !host_ready);

  // R12
  stat_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_empty && q_full));

  // R12
  accept_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_ready) |=> !q_empty);

  // R7
  vs_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vs_we |-> (int'(vs_addr) < VS_DEPTH));

  // R5
  low_byte_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_we && hi_seen) |-> (pat_addr == lo_addr));

  // R5
  pair_unbroken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_seen |-> !(cram_we || vs_we));

  // R4
  slot_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_pulse && gap_window) |->
      (int'(gap_q) == (wide_mode ? WIDE_CLKS - 1 : NARROW_CLKS - 1)));
endmodule

bind vram_wr_queue vwq_chk #(
  .WIDE_CLKS(WIDE_CLKS), .NARROW_CLKS(NARROW_CLKS), .VS_DEPTH(VS_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .host_valid(host_valid),
  .host_ready(host_ready), .slot_pulse(slot_pulse), .slot_idle(slot_idle),
  .pat_we(pat_we), .pat_addr(pat_addr), .cram_we(cram_we), .vs_we(vs_we),
  .vs_addr(vs_addr), .q_empty(q_empty), .q_full(q_full)
);

// File: tb/sim_vram_wr_queue.sv
`timescale 1ns/1ps
module sim_vram_wr_queue;
  localparam int LAT = 3;
  localparam int VSD = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide_mode = 1'b1;
  logic [7:0]  autoinc = 8'd2;
  logic        tgt_load = 1'b0;
  logic [15:0] tgt_addr = '0;
  logic [3:0]  tgt_cmd = '0;
  logic        host_valid = 1'b0;
  logic [15:0] host_data = '0;
  logic        host_ready, slot_pulse, slot_idle, pat_we, cram_we, vs_we;
  logic [15:0] pat_addr, cram_data, vs_data, stat_word;
  logic [7:0]  pat_byte;
  logic [5:0]  cram_addr, vs_addr;

  vram_wr_queue u0 (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .autoinc(autoinc),
    .tgt_load(tgt_load), .tgt_addr(tgt_addr), .tgt_cmd(tgt_cmd),
    .host_valid(host_valid), .host_data(host_data), .host_ready(host_ready),
    .slot_pulse(slot_pulse), .slot_idle(slot_idle), .pat_we(pat_we),
    .pat_addr(pat_addr), .pat_byte(pat_byte), .cram_we(cram_we),
    .cram_addr(cram_addr), .cram_data(cram_data), .vs_we(vs_we),
    .vs_addr(vs_addr), .vs_data(vs_data), .stat_word(stat_word)
  );

  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // {cmd[3:0], addr[15:0], data[15:0]}
  localparam logic [35:0] VEC [10] = '{
    36'h1_0100_A1B2, 36'h3_0012_0ABC, 36'h5_004E_0123, 36'h5_0050_0456,
    36'h5_00FE_0789, 36'h5_0080_0999, 36'h0_0200_DEAD, 36'h1_0301_5566,
    36'h7_0400_7777, 36'h3_007F_FFFF
  };

  // Reference queue model
  logic [15:0] m_addr [4];
  logic [15:0] m_data [4];
  logic [3:0]  m_cmd  [4];
  int          m_enq  [4];
  int m_cnt = 0, m_head = 0, pulses = 0, cyc = 0, last_pulse = 0, last_lat = -1;
  bit m_part = 0, saw_full = 0, prev_wide = 1, wide_chg = 0;
  logic [15:0] ma = '0;
  logic [3:0]  mc = '0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit acc;
      cyc++;
      acc = host_valid && host_ready;
      check(host_ready == (m_cnt < 4), "R2", "host_ready", host_ready, m_cnt < 4);
      if (!host_ready) saw_full = 1;
      check(stat_word == {6'b0, m_cnt == 0, m_cnt == 4, 8'b0}, "R12", "stat_word",
            stat_word, {6'b0, m_cnt == 0, m_cnt == 4, 8'b0});
      check($onehot0({pat_we, cram_we, vs_we}), "R10", "write enables",
            {pat_we, cram_we, vs_we}, 0);
      if (wide_mode != prev_wide) wide_chg = 1;
      prev_wide = wide_mode;
      if (slot_pulse) begin
        bit e_idle, e_pat, e_cr, e_vs, do_pop;
        logic [15:0] e_pa;
        logic [7:0]  e_pb;
        logic [5:0]  ix;
        int h;
        if (!wide_chg && pulses > 0)
          check(cyc - last_pulse == (wide_mode ? 16 : 20), "R4", "slot gap",
                cyc - last_pulse, wide_mode ? 16 : 20);
        wide_chg = 0;
        last_pulse = cyc;
        pulses++;
        e_idle = 1; e_pat = 0; e_cr = 0; e_vs = 0; do_pop = 0;
        e_pa = '0; e_pb = '0; ix = '0; h = m_head;
        if (m_cnt > 0 && (m_part || pulses - m_enq[h] >= LAT)) begin
          e_idle = 0;
          ix = m_addr[h][6:1];
          if (!m_part) last_lat = pulses - m_enq[h];
          case (m_cmd[h])
            4'h1: begin
              e_pat = 1;
              if (!m_part) begin e_pa = m_addr[h]; e_pb = m_data[h][15:8]; m_part = 1; end
              else begin e_pa = m_addr[h] ^ 16'h1; e_pb = m_data[h][7:0]; do_pop = 1; end
            end
            4'h3: begin e_cr = 1; do_pop = 1; end
            4'h5: begin e_vs = (int'(ix) < VSD); do_pop = 1; end
            default: do_pop = 1;
          endcase
        end
        check(slot_idle == e_idle, "R3 R9", "slot_idle", slot_idle, e_idle);
        check(pat_we == e_pat, "R5 R8", "pat_we", pat_we, e_pat);
        check(cram_we == e_cr, "R6 R8", "cram_we", cram_we, e_cr);
        check(vs_we == e_vs, "R7 R8", "vs_we", vs_we, e_vs);
        if (e_pat) begin
          check(pat_addr == e_pa, "R5 R11", "pat_addr", pat_addr, e_pa);
          check(pat_byte == e_pb, "R5 R10", "pat_byte", pat_byte, e_pb);
        end
        if (e_cr) begin
          check(cram_addr == ix, "R6", "cram_addr", cram_addr, ix);
          check(cram_data == m_data[h], "R6", "cram_data", cram_data, m_data[h]);
        end
        if (e_vs) begin
          check(vs_addr == ix, "R7", "vs_addr", vs_addr, ix);
          check(vs_data == m_data[h], "R7", "vs_data", vs_data, m_data[h]);
        end
        if (do_pop) begin
          m_head = (m_head + 1) % 4;
          m_cnt--;
          m_part = 0;
        end
      end else begin
        check(!(pat_we || cram_we || vs_we || slot_idle), "R10", "activity off slot",
              {pat_we, cram_we, vs_we, slot_idle}, 0);
      end
      if (acc) begin
        int t;
        t = (m_head + m_cnt) % 4;
        m_addr[t] = ma; m_data[t] = host_data; m_cmd[t] = mc; m_enq[t] = pulses;
        m_cnt++;
      end
      if (tgt_load) begin ma = tgt_addr; mc = tgt_cmd; end
      else if (acc) ma = ma + 16'(autoinc);
    end
  end

  task automatic load(input logic [15:0] a, input logic [3:0] c);
    @(posedge clk); #1;
    tgt_load = 1; tgt_addr = a; tgt_cmd = c;
    @(posedge clk); #1;
    tgt_load = 0;
  endtask

  task automatic write(input logic [15:0] d);
    host_valid = 1; host_data = d;
    forever begin
      @(negedge clk);
      if (host_ready) break;
    end
    @(posedge clk); #1;
    host_valid = 0;
  endtask

  task automatic drain_all();
    while (m_cnt != 0 || !stat_word[9]) begin
      @(posedge clk); #1;
    end
    repeat (2) @(posedge clk);
    #1;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check(stat_word == 16'h0200, "R1", "stat_word", stat_word, 16'h0200);
    check(host_ready == 1'b1, "R1", "host_ready", host_ready, 1);
    check(!(pat_we || cram_we || vs_we), "R1", "write enables",
          {pat_we, cram_we, vs_we}, 0);
    @(posedge clk); #1;

    // R3: single write into an empty queue drains on the 3rd slot
    load(16'h0040, 4'h3);
    write(16'h1234);
    drain_all();
    check(last_lat == LAT, "R3", "drain latency in slots", last_lat, LAT);

    // Vector table: every target and corner index
    for (int i = 0; i < 10; i++) begin
      load(VEC[i][31:16], VEC[i][35:32]);
      write(VEC[i][15:0]);
    end
    drain_all();

    // R2: back-to-back pattern burst fills the queue and stalls
    saw_full = 0;
    load(16'h1000, 4'h1);
    for (int i = 0; i < 7; i++) write(16'h1100 + 16'(i * 16'h0101));
    drain_all();
    check(saw_full, "R2", "stall observed", saw_full, 1);

    // R11: address wrap past 16'hFFFF
    load(16'hFFFF, 4'h1);
    write(16'hCAFE);
    write(16'hBEEF);
    drain_all();

    // R11: load in the same cycle as a write takes priority
    load(16'h0020, 4'h3);
    tgt_load = 1; tgt_addr = 16'h0030; tgt_cmd = 4'h5; host_valid = 1; host_data = 16'h0A0A;
    @(posedge clk); #1;
    tgt_load = 0; host_valid = 0;
    write(16'h0B0B);
    drain_all();

    // R4: narrow slots
    wide_mode = 0;
    load(16'h0004, 4'h3);
    for (int i = 0; i < 5; i++) write(16'h2000 + 16'(i));
    drain_all();
    repeat (60) @(posedge clk);
    #1 wide_mode = 1;
    repeat (60) @(posedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule